// File: doc/BRIEF.md
# Half-Duplex Command Sequencer

This block turns one host instruction into the chip-select frames needed by a peripheral that only talks half duplex. It sits above a frame engine. The frame engine asserts chip select, shifts bytes, and completes the peripheral's busy handshake. This block only decides how many frames to run, which byte goes out at each position, and which received bytes are kept.

A write-style instruction (SET) runs as a single frame that carries the instruction bytes. Everything the peripheral shifts back during that frame is dropped. A read-style instruction (GET) runs as two frames. The first carries the instruction, and its received bytes are dropped. The second frame starts only after the engine has reported that the first frame is fully finished. It sends filler bytes, its length equals the expected reply length, and the bytes it receives form the reply word.

The host presents a request while the block is idle. It gets back a one-cycle done pulse together with an error flag and the reply word. A register read, for example, is a GET whose instruction is opcode 0x04 followed by a one-byte register address, with a 4-byte reply.

Top module: `hdx_cmd_seq`

## Requirements
- R1: A request (`req_valid` high) is taken only while `req_ready` is high. `req_ready` is high after reset and drops in the cycle after a request is taken. A request presented while `req_ready` is low starts no frame and leaves the running sequence unchanged.
- R2: A SET request (`req_get`=0) produces exactly one frame. `fe_len` equals `req_len`. Byte k of the frame is `req_bytes[8k+7:8k]`, sent in order k = 0, 1, 2, ….
- R3: The reply word is cleared to zero when a request is taken. Bytes received during a SET frame, or during the first frame of a GET, never reach `rsp_word`.
- R4: A GET request (`req_get`=1) produces two frames. The first has length `req_len` and carries the instruction bytes as in R2. The second has length `req_rlen`.
- R5: Every byte offered in the second frame of a GET is the filler value 0xFF.
- R6: Reply byte k of the second frame lands in `rsp_word[8k+7:8k]`, so the first byte received sits in bits 7:0. Bytes above `req_rlen` stay zero. `rsp_word` does not change while the block is idle.
- R7: `fe_start` is a one-cycle pulse. The second frame's `fe_start` comes in the cycle after `fe_done` (without `fe_err`) for the first frame, and never earlier.
- R8: `fe_err` seen with `fe_done` ends the sequence. No further frame starts, and `rsp_done` pulses with `rsp_err`=1 in the next cycle.
- R9: `rsp_done` is high for one cycle per sequence. It comes in the cycle after the last `fe_done`, and `req_ready` is already high in that cycle.
- R10: A register read (instruction bytes 0x04 and an address, `req_len`=2, `req_rlen`=4) yields a 2-byte frame followed by a 4-byte filler frame, and returns the 4 reply bytes as one word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request strobe |
| req_get | input | 1 | 1 = GET (two frames), 0 = SET (one frame) |
| req_len | input | LENW | Instruction byte count, 1..MAX_TX |
| req_rlen | input | LENW | Expected reply byte count for GET, 1..RPL_BYTES |
| req_bytes | input | MAX_TX*8 | Instruction bytes, byte k in bits 8k+7:8k |
| req_ready | output | 1 | Idle and able to take a request |
| rsp_done | output | 1 | One-cycle end-of-sequence pulse |
| rsp_err | output | 1 | Frame engine error seen in this sequence |
| rsp_word | output | RPL_BYTES*8 | Reply, first received byte in bits 7:0 |
| fe_start | output | 1 | Start a frame |
| fe_len | output | LENW | Byte count of the frame being started |
| fe_tx_byte | output | 8 | Byte to send at the current position |
| fe_byte_stb | input | 1 | One byte exchanged; advances the position |
| fe_rx_byte | input | 8 | Byte received, valid with `fe_byte_stb` |
| fe_done | input | 1 | Frame and busy handshake complete |
| fe_err | input | 1 | Frame failed, valid with `fe_done` |

## Verification
The bench builds the block with its defaults, MAX_TX=8 and RPL_BYTES=4. That makes a full eight-byte SET payload and a full 32-bit reply reachable, as well as a short reply that leaves the top bytes empty. The frame engine model injects an error in either frame of a GET, so both abort points are covered. One request is driven while a GET is still in flight, to show that it is dropped.

// File: rtl/hdx_pkg.sv
package hdx_pkg;
  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_CMD  = 2'd1,
    S_RSP  = 2'd2
  } seq_state_t;

  localparam logic [7:0] FILL_DEFAULT = 8'hFF;
endpackage

// File: rtl/hdx_seq_fsm.sv
module hdx_seq_fsm
  import hdx_pkg::*;
#(
  parameter int LENW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic            req_get,
  input  logic [LENW-1:0] req_len,
  input  logic [LENW-1:0] req_rlen,
  input  logic            fe_done,
  input  logic            fe_err,
  output logic            ready,
  output logic            accept,
  output logic            in_rsp,
  output logic            fe_start,
  output logic [LENW-1:0] fe_len,
  output logic            done,
  output logic            err
);
  seq_state_t      state;
  logic            get_q;
  logic [LENW-1:0] rlen_q;

  assign ready  = (state == S_IDLE);
  assign accept = ready && req_valid;
  assign in_rsp = (state == S_RSP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      get_q    <= 1'b0;
      rlen_q   <= '0;
      fe_start <= 1'b0;
      fe_len   <= '0;
      done     <= 1'b0;
      err      <= 1'b0;
    end else begin
      fe_start <= 1'b0;
      done     <= 1'b0;
      unique case (state)
        S_IDLE: begin
          if (accept) begin
            get_q    <= req_get;
            rlen_q   <= req_rlen;
            fe_len   <= req_len;
            fe_start <= 1'b1;
            err      <= 1'b0;
            state    <= S_CMD;
          end
        end
        S_CMD: begin
          if (fe_done) begin
            if (fe_err) begin
              done  <= 1'b1;
              err   <= 1'b1;
              state <= S_IDLE;
            end else if (get_q) begin
              fe_len   <= rlen_q;
              fe_start <= 1'b1;
              state    <= S_RSP;
            end else begin
              done  <= 1'b1;
              state <= S_IDLE;
            end
          end
        end
        S_RSP: begin
          if (fe_done) begin
            done  <= 1'b1;
            err   <= fe_err;
            state <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/hdx_tx_pick.sv
module hdx_tx_pick #(
  parameter int         MAX_TX = 8,
  parameter int         LENW   = 4,
  parameter logic [7:0] FILL   = 8'hFF
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                accept,
  input  logic [MAX_TX*8-1:0] req_bytes,
  input  logic                fe_start,
  input  logic                fe_byte_stb,
  input  logic                in_rsp,
  output logic [LENW-1:0]     idx,
  output logic [7:0]          tx_byte
);
  localparam int TXW = MAX_TX * 8;

  logic [TXW-1:0] pay_q;

  function automatic logic [7:0] lane(input logic [TXW-1:0] p, input logic [LENW-1:0] i);
    logic [7:0] r;
    r = 8'h00;
    for (int k = 0; k < MAX_TX; k++)
      if (LENW'(k) == i) r = p[k*8 +: 8];
    return r;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pay_q <= '0;
      idx   <= '0;
    end else begin
      if (accept) pay_q <= req_bytes;
      if (fe_start) idx <= '0;
      else if (fe_byte_stb) idx <= idx + 1'b1;
    end
  end

  assign tx_byte = in_rsp ? FILL : lane(pay_q, idx);
endmodule

// File: rtl/hdx_rx_cap.sv
module hdx_rx_cap #(
  parameter int RPL_BYTES = 4,
  parameter int LENW      = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   accept,
  input  logic                   in_rsp,
  input  logic                   fe_byte_stb,
  input  logic [LENW-1:0]        idx,
  input  logic [7:0]             rx_byte,
  output logic [RPL_BYTES*8-1:0] word
);
  localparam int RW = RPL_BYTES * 8;

  function automatic logic [RW-1:0] merge(input logic [RW-1:0] w, input logic [LENW-1:0] i,
                                          input logic [7:0] b);
    logic [RW-1:0] r;
    r = w;
    for (int k = 0; k < RPL_BYTES; k++)
      if (LENW'(k) == i) r[k*8 +: 8] = b;
    return r;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) word <= '0;
    else if (accept) word <= '0;
    else if (in_rsp && fe_byte_stb) word <= merge(word, idx, rx_byte);
  end
endmodule

// File: rtl/hdx_cmd_seq.sv
module hdx_cmd_seq #(
  parameter int         MAX_TX    = 8,
  parameter int         RPL_BYTES = 4,
  parameter logic [7:0] FILL      = hdx_pkg::FILL_DEFAULT,
  localparam int        LENW      = $clog2(MAX_TX + 1),
  localparam int        TXW       = MAX_TX * 8,
  localparam int        RW        = RPL_BYTES * 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic            req_get,
  input  logic [LENW-1:0] req_len,
  input  logic [LENW-1:0] req_rlen,
  input  logic [TXW-1:0]  req_bytes,
  output logic            req_ready,
  output logic            rsp_done,
  output logic            rsp_err,
  output logic [RW-1:0]   rsp_word,
  output logic            fe_start,
  output logic [LENW-1:0] fe_len,
  output logic [7:0]      fe_tx_byte,
  input  logic            fe_byte_stb,
  input  logic [7:0]      fe_rx_byte,
  input  logic            fe_done,
  input  logic            fe_err
);
  logic            accept;
  logic            in_rsp;
  logic [LENW-1:0] idx;

  hdx_seq_fsm #(.LENW(LENW)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_get  (req_get),
    .req_len  (req_len),
    .req_rlen (req_rlen),
    .fe_done  (fe_done),
    .fe_err   (fe_err),
    .ready    (req_ready),
    .accept   (accept),
    .in_rsp   (in_rsp),
    .fe_start (fe_start),
    .fe_len   (fe_len),
    .done     (rsp_done),
    .err      (rsp_err)
  );

  hdx_tx_pick #(.MAX_TX(MAX_TX), .LENW(LENW), .FILL(FILL)) u_tx (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (accept),
    .req_bytes  (req_bytes),
    .fe_start   (fe_start),
    .fe_byte_stb(fe_byte_stb),
    .in_rsp     (in_rsp),
    .idx        (idx),
    .tx_byte    (fe_tx_byte)
  );

  hdx_rx_cap #(.RPL_BYTES(RPL_BYTES), .LENW(LENW)) u_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (accept),
    .in_rsp     (in_rsp),
    .fe_byte_stb(fe_byte_stb),
    .idx        (idx),
    .rx_byte    (fe_rx_byte),
    .word       (rsp_word)
  );
endmodule

// File: rtl/hdx_cmd_seq_chk.sv
module hdx_cmd_seq_chk #(
  parameter int         RW   = 32,
  parameter logic [7:0] FILL = 8'hFF
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          accept,
  input logic          in_rsp,
  input logic          fe_start,
  input logic [7:0]    fe_tx_byte,
  input logic          fe_done,
  input logic          fe_err,
  input logic          rsp_done,
  input logic          rsp_err,
  input logic [RW-1:0] rsp_word
);
  p_start_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    fe_start |-> !req_ready);
  p_accept_launch_r1: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (fe_start && !req_ready));
  p_fill_r5: assert property (@(posedge clk) disable iff (!rst_n)
    in_rsp |-> (fe_tx_byte == FILL));
  p_word_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && $past(req_ready)) |-> $stable(rsp_word));
  p_start_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fe_start |=> !fe_start);
  p_second_after_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fe_start && in_rsp) |-> ($past(fe_done) && !$past(fe_err)));
  p_err_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fe_done && fe_err && !req_ready) |=> (!fe_start && rsp_done && rsp_err));
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);
  p_done_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> req_ready);
endmodule

bind hdx_cmd_seq hdx_cmd_seq_chk #(.RW(RW), .FILL(FILL)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .accept    (accept),
  .in_rsp    (in_rsp),
  .fe_start  (fe_start),
  .fe_tx_byte(fe_tx_byte),
  .fe_done   (fe_done),
  .fe_err    (fe_err),
  .rsp_done  (rsp_done),
  .rsp_err   (rsp_err),
  .rsp_word  (rsp_word)
);

// File: tb/hdx_cmd_seq_tb.sv
`timescale 1ns/1ps
module hdx_cmd_seq_tb;
  localparam int LENW = 4;

  typedef struct packed {
    logic [3:0]  len;
    logic [63:0] bytes;
  } frm_t;
  typedef struct packed {
    logic [31:0] word;
    logic        err;
  } res_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_get = 1'b0;
  logic [LENW-1:0] req_len = '0, req_rlen = '0;
  logic [63:0] req_bytes = '0;
  logic req_ready, rsp_done, rsp_err, fe_start;
  logic [31:0] rsp_word;
  logic [LENW-1:0] fe_len;
  logic [7:0] fe_tx_byte;
  logic fe_byte_stb = 1'b0, fe_done = 1'b0, fe_err = 1'b0;
  logic [7:0] fe_rx_byte = 8'h00;

  int tests = 0, fails = 0;
  int gfr = 0, txn_fr = 0, err_frame = 0;
  bit finished = 1'b0, prev_done = 1'b0;
  frm_t fq[$];
  res_t rq[$];

  always #4 clk = ~clk;

  hdx_cmd_seq u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_get(req_get),
    .req_len(req_len), .req_rlen(req_rlen), .req_bytes(req_bytes),
    .req_ready(req_ready), .rsp_done(rsp_done), .rsp_err(rsp_err), .rsp_word(rsp_word),
    .fe_start(fe_start), .fe_len(fe_len), .fe_tx_byte(fe_tx_byte),
    .fe_byte_stb(fe_byte_stb), .fe_rx_byte(fe_rx_byte), .fe_done(fe_done), .fe_err(fe_err)
  );

  function automatic logic [7:0] rx_pat(input int f, input int i);
    return 8'((f * 37 + i * 11 + 5) & 255);
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  // Frame engine model: checks each frame against the scoreboard of expected frames
  task automatic do_frame();
    frm_t f;
    int n;
    n = int'(fe_len);
    gfr++;
    txn_fr++;
    if (fq.size() == 0) begin
      check(1'b0, "R1/R8 unexpected frame", 64'(n), 64'(0));
      f = '0;
    end else begin
      f = fq.pop_front();
      check(n == int'(f.len), "R2/R4 frame length", 64'(n), 64'(f.len));
    end
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      fe_byte_stb = 1'b0;
      @(negedge clk);
      check(!fe_start, "R7 start inside frame", 64'(fe_start), 64'(0));
      check(fe_tx_byte == f.bytes[i*8 +: 8], "R2/R5 tx byte", 64'(fe_tx_byte), 64'(f.bytes[i*8 +: 8]));
      fe_byte_stb = 1'b1;
      fe_rx_byte = rx_pat(gfr, i);
    end
    @(negedge clk);
    fe_byte_stb = 1'b0;
    repeat (3) begin
      @(negedge clk);
      check(!fe_start, "R7 start during busy", 64'(fe_start), 64'(0));
    end
    @(negedge clk);
    fe_done = 1'b1;
    fe_err = (txn_fr == err_frame);
  endtask

  initial begin
    forever begin
      @(negedge clk);
      fe_done = 1'b0;
      fe_err = 1'b0;
      if (rst_n && fe_start) do_frame();
    end
  end

  // Monitor: pops expected results as the design reports them
  always @(negedge clk) begin
    if (rst_n) begin
      if (rsp_done) begin
        res_t r;
        check(req_ready, "R9 ready with done", 64'(req_ready), 64'(1));
        if (rq.size() == 0) check(1'b0, "R9 unexpected done", 64'(1), 64'(0));
        else begin
          r = rq.pop_front();
          check(rsp_err == r.err, "R8 error flag", 64'(rsp_err), 64'(r.err));
          check(rsp_word == r.word, "R3/R6 reply word", 64'(rsp_word), 64'(r.word));
        end
      end
      if (prev_done && rsp_done) check(1'b0, "R9 done longer than one cycle", 64'(1), 64'(0));
      prev_done = rsp_done;
    end
  end

  task automatic run_txn(input bit get, input int len, input logic [63:0] pay, input int rlen,
                         input int errf, input bit poke);
    frm_t f;
    res_t r;
    int base;
    base = gfr;
    f.len = 4'(len);
    f.bytes = pay;
    fq.push_back(f);
    r.err = (errf != 0);
    r.word = '0;
    if (get && errf != 1) begin
      f.len = 4'(rlen);
      f.bytes = {8{8'hFF}};
      fq.push_back(f);
      for (int i = 0; i < rlen; i++) r.word[i*8 +: 8] = rx_pat(base + 2, i);
    end
    rq.push_back(r);
    err_frame = errf;
    txn_fr = 0;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_get = get;
    req_len = LENW'(len);
    req_rlen = LENW'(rlen);
    req_bytes = pay;
    @(negedge clk);
    req_valid = 1'b0;
    if (poke) begin
      repeat (3) @(negedge clk);
      check(!req_ready, "R1 busy while in flight", 64'(req_ready), 64'(0));
      req_valid = 1'b1;
      req_get = 1'b0;
      req_len = 4'd3;
      req_bytes = 64'h1111_2222_3333_4444;
      @(negedge clk);
      req_valid = 1'b0;
    end
    while (rq.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog", 64'(0), 64'(1));
    finish_up();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready, "R1 ready after reset", 64'(req_ready), 64'(1));
    check(!rsp_done && !fe_start, "R9 no pulses after reset", 64'({rsp_done, fe_start}), 64'(0));
    check(rsp_word == 32'h0, "R6 word zero after reset", 64'(rsp_word), 64'(0));

    // R10: register read, opcode 0x04 then address 0x12, 4-byte reply
    run_txn(1'b1, 2, 64'h12_04, 4, 0, 1'b0);
    // R3: SET after a GET clears the reply and drops received bytes
    run_txn(1'b0, 2, 64'h3C_A5, 0, 0, 1'b0);
    // R2: full eight-byte SET payload
    run_txn(1'b0, 8, 64'h8877_6655_4433_2211, 0, 0, 1'b0);
    // R6: short reply leaves upper bytes zero
    run_txn(1'b1, 3, 64'h9A_55_0B, 2, 0, 1'b0);
    // R8: error in first frame of GET, no second frame
    run_txn(1'b1, 2, 64'h07_04, 4, 1, 1'b0);
    // R8: error in second frame of GET
    run_txn(1'b1, 1, 64'h0C, 4, 2, 1'b0);
    // R8: error in a SET frame
    run_txn(1'b0, 4, 64'hDEAD_BEEF, 0, 1, 1'b0);
    // R1: request while busy is dropped
    run_txn(1'b1, 2, 64'h30_04, 1, 0, 1'b1);
    repeat (30) @(negedge clk);
    check(fq.size() == 0, "R1/R4 all expected frames seen", 64'(fq.size()), 64'(0));
    check(rq.size() == 0, "R9 all results seen", 64'(rq.size()), 64'(0));
    check(req_ready, "R1 idle at end", 64'(req_ready), 64'(1));
    finish_up();
  end
endmodule